// File: doc/BRIEF.md
# Asynchronous-Acknowledge Bus Cycle Sequencer

This block is a bus master that runs single read or write transfers against an external slave. It drives an active-low address strobe, an active-low data strobe and a read/write line. The slave ends each transfer by pulling an active-low, asynchronous acknowledge. The sequencer never looks for an edge on that acknowledge. It passes the acknowledge through a synchronizer chain and reads the result as a level, only at fixed points in the cycle. Until it sees the acknowledge, it inserts wait states.

The block runs on an internal clock at twice the bus rate. Each clock tick is one half-clock bus state, named S0 to S7, with wait-state pairs inserted as needed. The parameter `SAMPLE_STATE` selects where the first acknowledge sample is taken:
- At S4, the shortest transfer is four bus clocks (8 ticks).
- At S2, the shortest transfer is three bus clocks (6 ticks).

An acknowledge that is tied or held asserted is legal and gives back-to-back zero-wait transfers. An internal requester starts a transfer with a start pulse while the block is idle. It gets back a one-tick done pulse at the tick where both strobes return high.

Top module: `async_ack_bus_seq`

## Requirements
- R1: While reset is active, and afterwards until a transfer is accepted, `asN` and `dsN` are 1, `doneP` is 0 and `rnw` is 1.
- R2: `startReq` is accepted only in the idle state S0, and `rwIn` (1 = read, 0 = write) is captured at that tick. `rnw` shows the captured value from the next tick and stays stable for the whole transfer. Start pulses and `rwIn` changes during a transfer have no effect.
- R3: Take the accepting tick as tick 0. `asN` goes low at tick 1. `dsN` goes low at tick 1 for a read and at tick 2 for a write. Both stay low until the termination tick.
- R4: With the default `SYNC_STAGES` = 2, a decision taken at tick s uses the level that `ackN` had during tick s-2, which is one bus clock earlier.
- R5: The first decision is at tick `SAMPLE_STATE`. Each time the acknowledge is not seen, one bus clock (two ticks) of wait is added and the level is sampled again.
- R6: After a decision at tick s that sees the acknowledge asserted, both strobes stay low through ticks s+1 and s+2 and return high at tick s+3.
- R7: `doneP` is high for exactly one tick, the tick at which the strobes return high. The block is idle (strobes high) on the following tick.
- R8: An acknowledge that stays asserted after the strobes have returned high has no effect. Without a new start the block stays idle with both strobes high.
- R9: An acknowledge already asserted before the first sample point gives a zero-wait transfer: 8 ticks with `SAMPLE_STATE` = 4 and 6 ticks with `SAMPLE_STATE` = 2. With `startReq` and `ackN` held active, done pulses repeat every 8 or 6 ticks.
- R10: With `SAMPLE_STATE` = 2, states S3 and S4 are skipped. Transfers are two ticks shorter only when the acknowledge arrives early enough to be seen at tick 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, twice the bus clock rate; one tick per bus state |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Transfer request from the internal requester, sampled in idle only |
| rwIn | input | 1 | Direction of the requested transfer, 1 = read, 0 = write |
| ackN | input | 1 | Active-low asynchronous transfer acknowledge from the slave |
| asN | output | 1 | Active-low address strobe |
| dsN | output | 1 | Active-low data strobe |
| rnw | output | 1 | Read/write line held for the transfer, 1 = read |
| doneP | output | 1 | One-tick pulse at the end of a transfer |

## Verification
Every output is a register loaded from the next state, so a change caused by the input at tick k shows up at tick k+1. The strobes fall one tick after the start tick. The acknowledge affects a decision two ticks after it is driven, and the strobes rise three ticks after that decision. The bench numbers ticks from the start tick, drives inputs on the falling clock edge and reads outputs on the next falling edge. Each transfer's expected done tick is therefore a fixed tick number, worked out from the acknowledge tick and the sample state for both the four-clock and the three-clock instance. Zero-wait repetition is measured as the spacing between successive done pulses.

// File: rtl/async_ack_bus_pkg.sv
package async_ack_bus_pkg;

  typedef enum logic [3:0] {
    ST_S0 = 4'd0,
    ST_S1 = 4'd1,
    ST_S2 = 4'd2,
    ST_S3 = 4'd3,
    ST_S4 = 4'd4,
    ST_W0 = 4'd5,
    ST_W1 = 4'd6,
    ST_S5 = 4'd7,
    ST_S6 = 4'd8,
    ST_S7 = 4'd9
  } busState_e;

  // strobe requests from control to datapath, all for the coming tick
  typedef struct packed {
    logic asOn;    // address strobe active
    logic dsLate;  // data strobe active regardless of direction
    logic dsEarly; // data strobe active only for a read
    logic doneOn;  // termination tick
    logic loadRw;  // capture the direction input
  } busCtrl_t;

endpackage

// File: rtl/ack_level_sync.sv
module ack_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ackNAsync,
  output logic ackSeen
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= ~ackNAsync;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], ~ackNAsync};
      end
    end
  endgenerate

  assign ackSeen = chain[STAGES-1];

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import async_ack_bus_pkg::*;
#(
  parameter int SAMPLE_STATE = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     ackSeen,
  output busCtrl_t ctrl
);

  localparam bit FAST = (SAMPLE_STATE == 2);

  busState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_S0;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_S0: if (startReq) nextState = ST_S1;
      ST_S1: nextState = ST_S2;
      ST_S2: begin
        if (FAST) nextState = ackSeen ? ST_S5 : ST_W0;
        else      nextState = ST_S3;
      end
      ST_S3: nextState = ST_S4;
      ST_S4: nextState = ackSeen ? ST_S5 : ST_W0;
      ST_W0: nextState = ST_W1;
      ST_W1: nextState = ackSeen ? ST_S5 : ST_W0;
      ST_S5: nextState = ST_S6;
      ST_S6: nextState = ST_S7;
      ST_S7: nextState = ST_S0;
      default: nextState = ST_S0;
    endcase
  end

  always_comb begin
    ctrl.asOn    = (nextState != ST_S0) && (nextState != ST_S7);
    ctrl.dsLate  = ctrl.asOn && (nextState != ST_S1);
    ctrl.dsEarly = (nextState == ST_S1);
    ctrl.doneOn  = (nextState == ST_S7);
    ctrl.loadRw  = (state == ST_S0) && startReq;
  end

endmodule

// File: rtl/bus_strobe_dp.sv
module bus_strobe_dp
  import async_ack_bus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  busCtrl_t ctrl,
  input  logic     rwIn,
  output logic     asN,
  output logic     dsN,
  output logic     rnw,
  output logic     doneP
);

  logic rwNext;

  assign rwNext = ctrl.loadRw ? rwIn : rnw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asN   <= 1'b1;
      dsN   <= 1'b1;
      rnw   <= 1'b1;
      doneP <= 1'b0;
    end else begin
      asN   <= ~ctrl.asOn;
      dsN   <= ~(ctrl.dsLate | (ctrl.dsEarly & rwNext));
      rnw   <= rwNext;
      doneP <= ctrl.doneOn;
    end
  end

endmodule

// File: rtl/async_ack_bus_seq.sv
module async_ack_bus_seq
  import async_ack_bus_pkg::*;
#(
  parameter int SAMPLE_STATE = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic rwIn,
  input  logic ackN,
  output logic asN,
  output logic dsN,
  output logic rnw,
  output logic doneP
);

  busCtrl_t ctrl;
  logic     ackSeen;

  ack_level_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .ackNAsync (ackN),
    .ackSeen   (ackSeen)
  );

  bus_cycle_ctrl #(.SAMPLE_STATE(SAMPLE_STATE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .ackSeen  (ackSeen),
    .ctrl     (ctrl)
  );

  bus_strobe_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .rwIn  (rwIn),
    .asN   (asN),
    .dsN   (dsN),
    .rnw   (rnw),
    .doneP (doneP)
  );

endmodule

// File: rtl/async_ack_bus_seq_chk.sv
module async_ack_bus_seq_chk #(
  parameter int SAMPLE_STATE = 4
) (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic dsN,
  input logic rnw,
  input logic doneP
);

  localparam int MIN_LOW = SAMPLE_STATE + 2;

  logic [7:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowCnt <= '0;
    else if (!asN) begin
      if (lowCnt != 8'hFF)   lowCnt <= lowCnt + 8'd1;
    end else                 lowCnt <= '0;
  end

  // R3: data strobe only inside address strobe
  a_r3_ds_inside_as: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> !asN);

  // R3: read opens data strobe with address strobe
  a_r3_read_ds_early: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(asN) && rnw) |-> !dsN);

  // R3: write opens data strobe one tick later
  a_r3_write_ds_late: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(asN) && !rnw) |-> dsN);

  // R2: direction stable during a transfer
  a_r2_rw_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!asN && !$past(asN)) |-> $stable(rnw));

  // R7: done coincides with both strobes high
  a_r7_done_strobes_off: assert property (@(posedge clk) disable iff (!rstN)
    doneP |-> (asN && dsN));

  // R7: done is a single tick followed by idle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> (!doneP && asN));

  // R9: no transfer shorter than the zero-wait length
  a_r9_min_length: assert property (@(posedge clk) disable iff (!rstN)
    $rose(asN) |-> (lowCnt >= 8'(MIN_LOW)));

endmodule

bind async_ack_bus_seq async_ack_bus_seq_chk #(.SAMPLE_STATE(SAMPLE_STATE)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .asN   (asN),
  .dsN   (dsN),
  .rnw   (rnw),
  .doneP (doneP)
);

// File: tb/test_async_ack_bus_seq.sv
module test_async_ack_bus_seq;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  typedef struct packed {
    logic rw;
    int   ackAt;
    int   expSlow;
    int   expFast;
  } vec_t;

  // done tick = s + 3, s = first even decision tick >= sample state with s-2 >= ackAt
  localparam vec_t VECS [8] = '{
    '{1'b1, 0,  7,  5},
    '{1'b0, 0,  7,  5},
    '{1'b1, 1,  7,  7},
    '{1'b0, 2,  7,  7},
    '{1'b1, 3,  9,  9},
    '{1'b0, 4,  9,  9},
    '{1'b1, 6, 11, 11},
    '{1'b0, 9, 15, 15}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic rwIn = 1'b1;
  logic ackN = 1'b1;
  logic asN, dsN, rnw, doneP;
  logic asNF, dsNF, rnwF, donePF;

  int nChecks = 0;
  int nFails  = 0;
  int ticks   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_ack_bus_seq i_async_ack_bus_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rwIn(rwIn), .ackN(ackN),
    .asN(asN), .dsN(dsN), .rnw(rnw), .doneP(doneP));

  async_ack_bus_seq #(.SAMPLE_STATE(2)) i_async_ack_bus_seq_fast (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rwIn(rwIn), .ackN(ackN),
    .asN(asNF), .dsN(dsNF), .rnw(rnwF), .doneP(donePF));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > WATCHDOG) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, WATCHDOG);
      summary();
    end
  end

  task automatic runVec(input vec_t v);
    int doneS = -1;
    int doneF = -1;
    int lastK = v.expSlow + 2;
    @(negedge clk);
    startReq = 1'b1;
    rwIn     = v.rw;
    ackN     = (v.ackAt == 0) ? 1'b0 : 1'b1;
    for (int k = 1; k <= lastK; k++) begin
      @(negedge clk);
      if (k == 1) begin
        startReq = 1'b0;
        rwIn     = ~v.rw;
        chk(asN == 1'b0 && asNF == 1'b0, "R3 address strobe at tick 1", asN, 0);
        chk(dsN == ~v.rw, "R3 data strobe at tick 1 by direction", dsN, ~v.rw);
        chk(rnw == v.rw && rnwF == v.rw, "R2 direction captured", rnw, v.rw);
      end
      if (k == 2) chk(dsN == 1'b0 && dsNF == 1'b0, "R3 data strobe at tick 2", dsN, 0);
      if (k == v.expSlow - 1)
        chk(asN == 1'b0 && dsN == 1'b0 && rnw == v.rw, "R6 strobes held before end", asN, 0);
      if (doneS < 0 && doneP)  doneS = k;
      if (doneF < 0 && donePF) doneF = k;
      if (k == v.expFast + 1)
        chk(asNF == 1'b1 && donePF == 1'b0, "R8 fast idle with ack held", asNF, 1);
      if (k == v.expSlow + 1)
        chk(asN == 1'b1 && dsN == 1'b1 && doneP == 1'b0, "R8 idle with ack held", asN, 1);
      ackN = (k >= v.ackAt) ? 1'b0 : 1'b1;
    end
    chk(doneS == v.expSlow, "R5 done tick, sample at S4", doneS, v.expSlow);
    chk(doneF == v.expFast, "R10 done tick, sample at S2", doneF, v.expFast);
    ackN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(asN && dsN && !doneP && rnw, "R1 outputs during reset", {asN, dsN, doneP, rnw}, 4'b1101);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(asN && dsN && !doneP && rnw && asNF, "R1 idle after reset", {asN, dsN, doneP, rnw}, 4'b1101);

    foreach (VECS[i]) runVec(VECS[i]);

    // R4: ack pulsed only for tick 1 is seen at the tick-4 decision? No: tick 1 is not s-2 for s=4
    begin
      int doneS = -1;
      @(negedge clk);
      startReq = 1'b1; rwIn = 1'b1;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        startReq = 1'b0;
        if (doneS < 0 && doneP) doneS = k;
        ackN = (k == 1 || k >= 6) ? 1'b0 : 1'b1;
      end
      chk(doneS == 11, "R4 short ack before sample window missed", doneS, 11);
      ackN = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R2: start and direction changes while busy are ignored
    begin
      int dones = 0;
      bit rwOk = 1'b1;
      @(negedge clk);
      startReq = 1'b1; rwIn = 1'b0; ackN = 1'b0;
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        startReq = (k == 3 || k == 4);
        rwIn = k[0];
        if (k <= 6 && rnw != 1'b0) rwOk = 1'b0;
        if (doneP) dones++;
      end
      startReq = 1'b0;
      chk(rwOk, "R2 direction held while busy", rwOk, 1);
      chk(dones == 1, "R2 start ignored while busy", dones, 1);
      chk(asN == 1'b1, "R2 idle after ignored start", asN, 1);
    end

    // R9: ack tied asserted, start held: back-to-back minimum transfers
    begin
      int lastS = -1;
      int lastF = -1;
      int gapS  = 0;
      int gapF  = 0;
      int nS    = 0;
      int nF    = 0;
      ackN = 1'b0;
      repeat (4) @(negedge clk);
      startReq = 1'b1; rwIn = 1'b1;
      for (int k = 1; k <= 40; k++) begin
        @(negedge clk);
        if (doneP) begin
          if (lastS >= 0) begin gapS = k - lastS; nS++;
            chk(gapS == 8, "R9 back-to-back spacing, S4", gapS, 8); end
          lastS = k;
        end
        if (donePF) begin
          if (lastF >= 0) begin gapF = k - lastF; nF++;
            chk(gapF == 6, "R9 back-to-back spacing, S2", gapF, 6); end
          lastF = k;
        end
      end
      chk(nS >= 3 && nF >= 4, "R9 repeated transfers observed", nS, 3);
      startReq = 1'b0;
      ackN = 1'b1;
      repeat (12) @(negedge clk);
      chk(asN && dsN && asNF && dsNF, "R8 idle after tied ack released", asN, 1);
    end

    summary();
  end

endmodule